// File: doc/BRIEF.md
# Transfer Status and Error Flag Unit

This block sits beside a FIFO-based serial engine and turns the engine's raw status lines and one-cycle event pulses into readable flag registers and a single active-high, level interrupt. FIFO fill indications (not-empty and full, for the receive and transmit sides) are shown live. Service requests, max-count-done events and error events are captured in sticky flags that hold until software clears them.

Errors fall into two banks, each with its own enable register. The FIFO bank records overrun and underrun on either side. The serial-clock bank records clock overrun and underrun. An operational mask register can keep the service flags from reaching the interrupt. The done flags always reach it. Software reads a register, writes the same value back to acknowledge every flag it saw, and leaves untouched any flag that rose afterwards.

The register port is a plain synchronous one. Read data is registered and so is the interrupt, as an FPGA timing budget favours.

Top module: `xfer_flag_unit`

## Requirements
- R1: After a synchronous reset, all sticky flags, enables, the mask, `irq` and `reg_rdata` are zero.
- R2: Address 0 shows the live FIFO levels: bit 7 receive-full, bit 6 transmit-full, bit 5 receive-not-empty and bit 4 transmit-not-empty. Writes do not change these bits.
- R3: An event pulse sets its sticky flag, and the flag holds until cleared. At address 0: bit 11 receive-done, bit 10 transmit-done, bit 9 receive-service, bit 8 transmit-service. At address 1: bit 5 transmit overrun, bit 4 receive underrun, bit 3 transmit underrun, bit 2 receive overrun. At address 3: bit 1 clock overrun, bit 0 clock underrun.
- R4: Writing 1 to a sticky flag bit clears that flag. Writing 0 leaves the flag as it is. Writing back a value that was read clears exactly the flags it showed.
- R5: If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Address 2 holds the FIFO error enables in bits 5:2, and address 4 holds the clock error enables in bits 1:0. Both read back, and all other bits read as 0.
- R7: `irq` is high in the cycle after the flag state holds any of the following: an enabled error flag, a done flag, or an unmasked service flag.
- R8: Address 5 bits 9 and 8 mask the receive and transmit service flags from `irq`. The mask has no effect on the done or error flags.
- R9: `reg_rdata` shows, one clock after `reg_addr` is sampled, that register's value before the same edge's updates. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_not_empty | input | 1 | Live: receive FIFO holds data |
| tx_not_empty | input | 1 | Live: transmit FIFO holds data |
| rx_full | input | 1 | Live: receive FIFO full |
| tx_full | input | 1 | Live: transmit FIFO full |
| ev_rx_done | input | 1 | Pulse: receive max count reached |
| ev_tx_done | input | 1 | Pulse: transmit max count reached |
| ev_rx_svc | input | 1 | Pulse: receive side needs service |
| ev_tx_svc | input | 1 | Pulse: transmit side needs service |
| ev_tx_ovr | input | 1 | Pulse: transmit FIFO overrun |
| ev_rx_udr | input | 1 | Pulse: receive FIFO underrun |
| ev_tx_udr | input | 1 | Pulse: transmit FIFO underrun |
| ev_rx_ovr | input | 1 | Pulse: receive FIFO overrun |
| ev_clk_ovr | input | 1 | Pulse: serial clock overrun |
| ev_clk_udr | input | 1 | Pulse: serial clock underrun |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, active high |

## Verification
Directed patterns come first. One pulses a single event at a time to show that each flag sits in its own bit. One writes back the value just read, and another clears only part of a register, to tell a full acknowledge from a selective one. One collides an event with a clear of the same bit, which separates set priority from clear priority. Service and done flags are driven against the mask to show that the mask gates only service, and enables are driven against errors to show which bank feeds `irq`. A long random phase then mixes events, writes to every address and toggling FIFO levels, and every cycle it compares read data and the interrupt with a reference model kept in the bench.

// File: rtl/xfer_flag_pkg.sv
`timescale 1ns/1ps
package xfer_flag_pkg;
  // register word addresses
  localparam int A_STAT = 0;
  localparam int A_FERR = 1;
  localparam int A_FEN  = 2;
  localparam int A_CERR = 3;
  localparam int A_CEN  = 4;
  localparam int A_MASK = 5;
  // field positions
  localparam int LIVE_LSB = 4;   // 4 live FIFO level bits
  localparam int OP_LSB   = 8;   // 4 sticky service/done bits
  localparam int OP_W     = 4;
  localparam int LIVE_W   = 4;
  localparam int FE_LSB   = 2;   // 4 FIFO error bits
  localparam int FE_W     = 4;
  localparam int CE_LSB   = 0;   // 2 clock error bits
  localparam int CE_W     = 2;
  localparam int MASK_LSB = 8;   // service mask bits
  localparam int MASK_W   = 2;
  localparam int SVC_W    = 2;   // low bits of the op field are service
endpackage

// File: rtl/sticky_bank.sv
`timescale 1ns/1ps
module sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q_o[i] <= 1'b0;
      else     q_o[i] <= set_i[i] | (q_o[i] & ~clr_i[i]);
    end

    // R5: an event wins over a same-cycle clear
    a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> q_o[i]);
    // R4: a clear without an event empties the flag
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    // R3: a flag holds while nobody clears it
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      (q_o[i] && !clr_i[i]) |=> q_o[i]);
  end
endmodule

// File: rtl/flag_readback.sv
`timescale 1ns/1ps
module flag_readback import xfer_flag_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LIVE_W-1:0] live_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [FE_W-1:0]   fe_i,
  input  logic [FE_W-1:0]   fen_i,
  input  logic [CE_W-1:0]   ce_i,
  input  logic [CE_W-1:0]   cen_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [DATA_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    case (int'(addr_i))
      A_STAT: begin
        word_o[OP_LSB +: OP_W]     = op_i;
        word_o[LIVE_LSB +: LIVE_W] = live_i;
      end
      A_FERR:  word_o[FE_LSB +: FE_W]     = fe_i;
      A_FEN:   word_o[FE_LSB +: FE_W]     = fen_i;
      A_CERR:  word_o[CE_LSB +: CE_W]     = ce_i;
      A_CEN:   word_o[CE_LSB +: CE_W]     = cen_i;
      A_MASK:  word_o[MASK_LSB +: MASK_W] = mask_i;
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_combiner.sv
`timescale 1ns/1ps
module irq_combiner import xfer_flag_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [FE_W-1:0]   fe_i,
  input  logic [FE_W-1:0]   fen_i,
  input  logic [CE_W-1:0]   ce_i,
  input  logic [CE_W-1:0]   cen_i,
  output logic              irq_o
);
  logic err_any, done_any, svc_any, pend;

  always_comb begin
    err_any  = |(fe_i & fen_i) | |(ce_i & cen_i);
    done_any = |op_i[OP_W-1:SVC_W];
    svc_any  = |(op_i[SVC_W-1:0] & ~mask_i);
    pend     = err_any | done_any | svc_any;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= pend;
  end

  // R8: masked service alone never raises the interrupt
  a_r8_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    (((op_i[SVC_W-1:0] & ~mask_i) == '0) && !done_any && !err_any) |=> !irq_o);
  // R7: a done flag always reaches the interrupt
  a_r7_done_irq: assert property (@(posedge clk) disable iff (rst)
    done_any |=> irq_o);
endmodule

// File: rtl/xfer_flag_unit.sv
`timescale 1ns/1ps
module xfer_flag_unit import xfer_flag_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_not_empty,
  input  logic              tx_not_empty,
  input  logic              rx_full,
  input  logic              tx_full,
  input  logic              ev_rx_done,
  input  logic              ev_tx_done,
  input  logic              ev_rx_svc,
  input  logic              ev_tx_svc,
  input  logic              ev_tx_ovr,
  input  logic              ev_rx_udr,
  input  logic              ev_tx_udr,
  input  logic              ev_rx_ovr,
  input  logic              ev_clk_ovr,
  input  logic              ev_clk_udr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [LIVE_W-1:0] live;
  logic [OP_W-1:0]   op_set, op_clr, op_q;
  logic [FE_W-1:0]   fe_set, fe_clr, fe_q, fen_q;
  logic [CE_W-1:0]   ce_set, ce_clr, ce_q, cen_q;
  logic [MASK_W-1:0] mask_q;
  logic [DATA_W-1:0] rd_word;
  logic wr_stat, wr_ferr, wr_fen, wr_cerr, wr_cen, wr_mask;

  always_comb begin
    live    = {rx_full, tx_full, rx_not_empty, tx_not_empty};
    op_set  = {ev_rx_done, ev_tx_done, ev_rx_svc, ev_tx_svc};
    fe_set  = {ev_tx_ovr, ev_rx_udr, ev_tx_udr, ev_rx_ovr};
    ce_set  = {ev_clk_ovr, ev_clk_udr};
    wr_stat = reg_wr && (int'(reg_addr) == A_STAT);
    wr_ferr = reg_wr && (int'(reg_addr) == A_FERR);
    wr_fen  = reg_wr && (int'(reg_addr) == A_FEN);
    wr_cerr = reg_wr && (int'(reg_addr) == A_CERR);
    wr_cen  = reg_wr && (int'(reg_addr) == A_CEN);
    wr_mask = reg_wr && (int'(reg_addr) == A_MASK);
    op_clr  = wr_stat ? reg_wdata[OP_LSB +: OP_W] : '0;
    fe_clr  = wr_ferr ? reg_wdata[FE_LSB +: FE_W] : '0;
    ce_clr  = wr_cerr ? reg_wdata[CE_LSB +: CE_W] : '0;
  end

  sticky_bank #(.W(OP_W)) u_op_bank (
    .clk(clk), .rst(rst), .set_i(op_set), .clr_i(op_clr), .q_o(op_q));
  sticky_bank #(.W(FE_W)) u_fe_bank (
    .clk(clk), .rst(rst), .set_i(fe_set), .clr_i(fe_clr), .q_o(fe_q));
  sticky_bank #(.W(CE_W)) u_ce_bank (
    .clk(clk), .rst(rst), .set_i(ce_set), .clr_i(ce_clr), .q_o(ce_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      fen_q  <= '0;
      cen_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_fen)  fen_q  <= reg_wdata[FE_LSB +: FE_W];
      if (wr_cen)  cen_q  <= reg_wdata[CE_LSB +: CE_W];
      if (wr_mask) mask_q <= reg_wdata[MASK_LSB +: MASK_W];
    end
  end

  flag_readback #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_read (
    .addr_i(reg_addr), .live_i(live), .op_i(op_q), .fe_i(fe_q),
    .fen_i(fen_q), .ce_i(ce_q), .cen_i(cen_q), .mask_i(mask_q),
    .word_o(rd_word));

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_word;
  end

  irq_combiner u_irq (
    .clk(clk), .rst(rst), .op_i(op_q), .mask_i(mask_q), .fe_i(fe_q),
    .fen_i(fen_q), .ce_i(ce_q), .cen_i(cen_q), .irq_o(irq));

  // R2: status reads carry the live FIFO levels of the sampling edge
  a_r2_live_bits: assert property (@(posedge clk) disable iff (rst)
    (int'(reg_addr) == A_STAT) |=>
      (reg_rdata[LIVE_LSB +: LIVE_W] == $past(live)));
  // R9: unmapped addresses read as zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (int'(reg_addr) > A_MASK) |=> (reg_rdata == '0));
  // R6: a write of the clock enables is visible on the next read of them
  a_r6_cen_load: assert property (@(posedge clk) disable iff (rst)
    wr_cen |=> (cen_q == $past(reg_wdata[CE_LSB +: CE_W])));
endmodule

// File: tb/test_xfer_flag_unit.sv
`timescale 1ns/1ps
module test_xfer_flag_unit;
  localparam int DW = 32;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] live = '0;   // {rx_full, tx_full, rx_ne, tx_ne}
  logic [3:0] evop = '0;   // {rx_done, tx_done, rx_svc, tx_svc}
  logic [3:0] evfe = '0;   // {tx_ovr, rx_udr, tx_udr, rx_ovr}
  logic [1:0] evce = '0;   // {clk_ovr, clk_udr}
  logic [AW-1:0] addr = '0;
  logic wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [3:0] m_op, m_fe, m_fen, m_live_unused;
  logic [1:0] m_ce, m_cen, m_mask;
  logic [DW-1:0] m_rdata;
  logic m_irq;

  always #2.5 clk = ~clk;

  xfer_flag_unit #(.DATA_W(DW), .ADDR_W(AW)) i_xfer_flag_unit (
    .clk(clk), .rst(rst),
    .rx_not_empty(live[1]), .tx_not_empty(live[0]),
    .rx_full(live[3]), .tx_full(live[2]),
    .ev_rx_done(evop[3]), .ev_tx_done(evop[2]),
    .ev_rx_svc(evop[1]), .ev_tx_svc(evop[0]),
    .ev_tx_ovr(evfe[3]), .ev_rx_udr(evfe[2]),
    .ev_tx_udr(evfe[1]), .ev_rx_ovr(evfe[0]),
    .ev_clk_ovr(evce[1]), .ev_clk_udr(evce[0]),
    .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq(irq));

  function automatic logic [DW-1:0] f_read(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    w = '0;
    case (a)
      3'd0: begin w[11:8] = m_op; w[7:4] = live; end
      3'd1: w[5:2] = m_fe;
      3'd2: w[5:2] = m_fen;
      3'd3: w[1:0] = m_ce;
      3'd4: w[1:0] = m_cen;
      3'd5: w[9:8] = m_mask;
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic f_irq();
    return (|(m_fe & m_fen)) | (|(m_ce & m_cen)) | m_op[3] | m_op[2] |
           (|(m_op[1:0] & ~m_mask));
  endfunction

  task automatic model_reset();
    m_op = '0; m_fe = '0; m_fen = '0; m_ce = '0; m_cen = '0;
    m_mask = '0; m_rdata = '0; m_irq = 1'b0;
  endtask

  task automatic model_step();
    logic [3:0] opc, fec;
    logic [1:0] cec;
    if (rst) begin model_reset(); return; end
    m_rdata = f_read(addr);
    m_irq = f_irq();
    opc = (wr && addr == 3'd0) ? wdata[11:8] : 4'h0;
    fec = (wr && addr == 3'd1) ? wdata[5:2]  : 4'h0;
    cec = (wr && addr == 3'd3) ? wdata[1:0]  : 2'h0;
    m_op = evop | (m_op & ~opc);
    m_fe = evfe | (m_fe & ~fec);
    m_ce = evce | (m_ce & ~cec);
    if (wr && addr == 3'd2) m_fen  = wdata[5:2];
    if (wr && addr == 3'd4) m_cen  = wdata[1:0];
    if (wr && addr == 3'd5) m_mask = wdata[9:8];
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: model follows the edge, outputs sampled at the falling edge
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({tag, " rdata"}, rdata, m_rdata);
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic w,
                       input logic [DW-1:0] d);
    addr = a; wr = w; wdata = d;
  endtask

  task automatic quiet();
    evop = '0; evfe = '0; evce = '0; wr = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    @(negedge clk);
    cyc("R1"); cyc("R1");
    rst = 1'b0;
    // R1: every register reads zero after reset
    for (int a = 0; a < 6; a++) begin
      drive(a[AW-1:0], 1'b0, '0);
      cyc("R1"); cyc("R1");
    end

    // R2: live levels, and writes cannot touch them
    drive(3'd0, 1'b0, '0);
    live = 4'b1010; cyc("R2"); cyc("R2");
    live = 4'b0101; cyc("R2");
    drive(3'd0, 1'b1, 32'hFFFF_FFFF); cyc("R2");
    wr = 1'b0; cyc("R2"); cyc("R2");
    live = '0;

    // R3: each event lands in its own bit and holds
    for (int b = 0; b < 4; b++) begin
      evop = 4'(1 << b); drive(3'd0, 1'b0, '0); cyc("R3");
      quiet(); cyc("R3"); cyc("R3");
      evfe = 4'(1 << b); drive(3'd1, 1'b0, '0); cyc("R3");
      quiet(); cyc("R3"); cyc("R3");
    end
    for (int b = 0; b < 2; b++) begin
      evce = 2'(1 << b); drive(3'd3, 1'b0, '0); cyc("R3");
      quiet(); cyc("R3"); cyc("R3");
    end

    // R4: partial clear, then write back the read value
    drive(3'd1, 1'b1, 32'h0000_0014); cyc("R4");
    quiet(); cyc("R4"); cyc("R4");
    check("R4 fifo err after partial clear", rdata, 32'h0000_0028);
    drive(3'd1, 1'b1, rdata); cyc("R4");
    quiet(); cyc("R4"); cyc("R4");
    check("R4 fifo err after write back", rdata, 32'h0);
    drive(3'd0, 1'b1, 32'h0000_0F00); cyc("R4");
    quiet(); drive(3'd3, 1'b1, 32'h3); cyc("R4");
    quiet(); cyc("R4"); cyc("R4");

    // R5: set and clear of the same bit in one cycle
    evfe = 4'b1000; drive(3'd1, 1'b1, 32'h0000_0020); cyc("R5");
    quiet(); cyc("R5"); cyc("R5");
    check("R5 flag kept", rdata, 32'h0000_0020);

    // R6: enables read back only their own bits
    drive(3'd2, 1'b1, 32'hFFFF_FFFF); cyc("R6");
    quiet(); cyc("R6"); cyc("R6");
    check("R6 fifo enables", rdata, 32'h0000_003C);
    drive(3'd4, 1'b1, 32'hFFFF_FFFF); cyc("R6");
    quiet(); cyc("R6"); cyc("R6");
    check("R6 clock enables", rdata, 32'h0000_0003);

    // R7: enabled error drives irq; disabling it drops irq
    check("R7 irq from enabled fifo error", {31'b0, irq}, 32'h1);
    drive(3'd2, 1'b1, 32'h0); cyc("R7");
    quiet(); cyc("R7"); cyc("R7");
    check("R7 irq off when disabled", {31'b0, irq}, 32'h0);
    evce = 2'b01; cyc("R7"); quiet(); cyc("R7"); cyc("R7");
    check("R7 irq from clock error", {31'b0, irq}, 32'h1);
    drive(3'd3, 1'b1, 32'h3); cyc("R7"); quiet(); cyc("R7"); cyc("R7");

    // R8: mask hides service but not done
    drive(3'd5, 1'b1, 32'h0000_0300); cyc("R8");
    quiet(); evop = 4'b0011; cyc("R8");
    quiet(); cyc("R8"); cyc("R8");
    check("R8 masked service quiet", {31'b0, irq}, 32'h0);
    evop = 4'b0100; cyc("R8"); quiet(); cyc("R8"); cyc("R8");
    check("R8 done ignores mask", {31'b0, irq}, 32'h1);
    drive(3'd0, 1'b1, 32'h0000_0400); cyc("R8");
    quiet(); drive(3'd5, 1'b1, 32'h0); cyc("R8");
    quiet(); cyc("R8"); cyc("R8");
    check("R8 unmasked service", {31'b0, irq}, 32'h1);

    // R9: unmapped addresses
    drive(3'd6, 1'b1, 32'hFFFF_FFFF); cyc("R9");
    quiet(); drive(3'd7, 1'b0, '0); cyc("R9"); cyc("R9");
    check("R9 unmapped", rdata, 32'h0);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      addr  = AW'($urandom % 8);
      wr    = ($urandom % 4) == 0;
      wdata = $urandom;
      live  = 4'($urandom);
      for (int b = 0; b < 4; b++) begin
        evop[b] = ($urandom % 8) == 0;
        evfe[b] = ($urandom % 8) == 0;
      end
      for (int b = 0; b < 2; b++) evce[b] = ($urandom % 8) == 0;
      cyc("R7 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule